// File: doc/BRIEF.md
# Cascadable Dual Counter Pair

This block holds two W-bit up-counters, a low counter and a high counter. Each counter picks its own count source: a rising edge on a dedicated external pin, a slow internal clock enable, or a fast internal clock enable. Every source is a synchronous clock enable in the single `clk` domain. External pins first pass through a two-flop synchronizer and then a rising-edge detector.

The low counter has a run field. It can be halted, it can run freely, or it can advance only while one of two external gate pins is high. When a gate pin stops a gated counter, a gate event is recorded. A chain bit joins the two counters into one 2W-bit counter. In that mode each wrap of the low counter advances the high counter, and the high counter's own source is ignored. Software loads either counter through a write port and reads both counters on dedicated outputs.

There are three event flags: gate stop, low wrap and high wrap. Each flag is sticky and is cleared by writing a 1 to it. One interrupt line is the OR of the enabled flags. In chained mode the low wrap is an internal carry and never raises its flag.

Top module: `dual_cascade_counter`

## Requirements
- R1: After reset both counters read 0, all three status flags (stat[0] gate, stat[1] low wrap, stat[2] high wrap) are 0, and irq is 0.
- R2: A cycle with wr_en high loads wr_data into the low counter when wr_sel is 0, or into the high counter when wr_sel is 1. The value appears on the outputs after that clock edge.
- R3: Source select codes are 0 = external pin rising edge (seen two clocks after synchronization), 1 = tick_slow, and 2 or 3 = tick_fast. A counter advances by one per cycle in which its selected source is active, and only then.
- R4: The low counter's run field codes are 0 = halted, 1 = free-running, 2 = counts only while gate_in0 is high, and 3 = counts only while gate_in1 is high.
- R5: In 8-bit pair mode (cfg_chain=0) each counter wraps from all-ones to 0. A low wrap sets stat[1] and a high wrap sets stat[2].
- R6: In chained mode (cfg_chain=1) the high counter advances exactly when the low counter wraps, and its own source is ignored. The pair behaves as one counter of twice the width.
- R7: In chained mode stat[1] is never set. stat[2] is set when the combined counter wraps from all-ones to 0.
- R8: stat[0] is set when the run field is 2 or 3 and the selected gate pin falls, which stops the counter. A gate falling in free-run or halt mode sets nothing.
- R9: Status flags stay set until a 1 is written to the matching clr_stat bit. An event that arrives in the same cycle as its clear leaves the flag set. irq is high exactly when some flag and its irq_en bit are both 1.
- R10: A software write to a counter wins over an increment of that counter in the same cycle, and such a cycle records no wrap event for that counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_fast | input | 1 | Fast internal count enable |
| tick_slow | input | 1 | Slow internal count enable |
| ext_clk_lo | input | 1 | External count pin, low counter |
| ext_clk_hi | input | 1 | External count pin, high counter |
| gate_in0 | input | 1 | Gate pin 0 |
| gate_in1 | input | 1 | Gate pin 1 |
| cfg_src_lo | input | 2 | Source select, low counter |
| cfg_src_hi | input | 2 | Source select, high counter |
| cfg_run | input | 2 | Run field of the low counter |
| cfg_chain | input | 1 | 1 = chained 2W-bit mode |
| wr_en | input | 1 | Counter write strobe |
| wr_sel | input | 1 | Write target: 0 low, 1 high |
| wr_data | input | W | Write value |
| clr_stat | input | 3 | Write-1-to-clear for status flags |
| irq_en | input | 3 | Interrupt enable per flag |
| cnt_lo | output | W | Low counter value |
| cnt_hi | output | W | High counter value |
| stat | output | 3 | Status flags {high wrap, low wrap, gate} |
| irq | output | 1 | Interrupt request |

## Verification
Written start values are swept across the whole byte range and read back. Counters are then driven through runs long enough to wrap, and the result is compared against the start value plus the tick count taken modulo the counter width. Running the same arithmetic on the joined 16-bit value in chained mode shows whether carries ripple correctly and whether the flag sources follow the mode. Each source code is driven with only the other sources active, which shows that a counter cannot count from the wrong source. Gate pins are raised and dropped in each run mode, which separates a real gate stop from a gate edge that must be ignored. Writes are placed on the same cycle as increments, and clears on the same cycle as wrap events, to check that the priority goes the right way.

// File: rtl/dual_cascade_counter.sv
module dual_cascade_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_fast,
  input  logic         tick_slow,
  input  logic         ext_clk_lo,
  input  logic         ext_clk_hi,
  input  logic         gate_in0,
  input  logic         gate_in1,
  input  logic [1:0]   cfg_src_lo,
  input  logic [1:0]   cfg_src_hi,
  input  logic [1:0]   cfg_run,
  input  logic         cfg_chain,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   clr_stat,
  input  logic [2:0]   irq_en,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi,
  output logic [2:0]   stat,
  output logic         irq
);

  logic [1:0] sy_lo, sy_hi, sy_g0, sy_g1;
  logic       pv_lo, pv_hi, pv_gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_lo <= '0; sy_hi <= '0; sy_g0 <= '0; sy_g1 <= '0;
      pv_lo <= 1'b0; pv_hi <= 1'b0; pv_gate <= 1'b0;
    end else begin
      sy_lo <= {sy_lo[0], ext_clk_lo};
      sy_hi <= {sy_hi[0], ext_clk_hi};
      sy_g0 <= {sy_g0[0], gate_in0};
      sy_g1 <= {sy_g1[0], gate_in1};
      pv_lo <= sy_lo[1];
      pv_hi <= sy_hi[1];
      pv_gate <= gate_lvl;
    end
  end

  logic edge_lo, edge_hi, src_lo, src_hi, gate_lvl, run_ok;
  assign edge_lo = sy_lo[1] & ~pv_lo;
  assign edge_hi = sy_hi[1] & ~pv_hi;

  always_comb begin
    case (cfg_src_lo)
      2'd0:    src_lo = edge_lo;
      2'd1:    src_lo = tick_slow;
      default: src_lo = tick_fast;
    endcase
    case (cfg_src_hi)
      2'd0:    src_hi = edge_hi;
      2'd1:    src_hi = tick_slow;
      default: src_hi = tick_fast;
    endcase
  end

  assign gate_lvl = cfg_run[0] ? sy_g1[1] : sy_g0[1];
  assign run_ok   = (cfg_run == 2'd1) | (cfg_run[1] & gate_lvl);

  logic wr_lo, wr_hi, step_lo, step_hi, wrap_lo, wrap_hi, gate_stop;
  assign wr_lo     = wr_en & ~wr_sel;
  assign wr_hi     = wr_en & wr_sel;
  assign step_lo   = src_lo & run_ok & ~wr_lo;
  assign wrap_lo   = step_lo & (&cnt_lo);
  assign step_hi   = (cfg_chain ? wrap_lo : src_hi) & ~wr_hi;
  assign wrap_hi   = step_hi & (&cnt_hi);
  assign gate_stop = cfg_run[1] & pv_gate & ~gate_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
      stat   <= '0;
    end else begin
      if (wr_lo)        cnt_lo <= wr_data;
      else if (step_lo) cnt_lo <= cnt_lo + 1'b1;
      if (wr_hi)        cnt_hi <= wr_data;
      else if (step_hi) cnt_hi <= cnt_hi + 1'b1;
      stat <= (stat & ~clr_stat) | {wrap_hi, wrap_lo & ~cfg_chain, gate_stop};
    end
  end

  assign irq = |(stat & irq_en);

  // R10
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (cnt_lo == $past(wr_data)));

  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_run == 2'd0 && !wr_en) |=> $stable(cnt_lo));

  // R6
  chain_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_chain && !(&cnt_lo) && !wr_en) |=> $stable(cnt_hi));

  // R7
  chain_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_chain && !stat[1]) |=> !stat[1]);

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat & ~clr_stat) & ~stat) == 3'b000));

endmodule

// File: tb/test_dual_cascade_counter.sv
module test_dual_cascade_counter;
  logic clk = 0, rst_n = 0;
  logic tick_fast = 0, tick_slow = 0, ext_clk_lo = 0, ext_clk_hi = 0;
  logic gate_in0 = 0, gate_in1 = 0, cfg_chain = 0, wr_en = 0, wr_sel = 0;
  logic [1:0] cfg_src_lo = 2, cfg_src_hi = 1, cfg_run = 1;
  logic [7:0] wr_data = 0;
  logic [2:0] clr_stat = 0, irq_en = 3'b111;
  logic [7:0] cnt_lo, cnt_hi;
  logic [2:0] stat;
  logic irq;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  dual_cascade_counter #(.W(8)) i_dual_cascade_counter (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d; cyc(1); wr_en = 0;
  endtask

  task automatic clr();
    clr_stat = 3'b111; cyc(1); clr_stat = 0;
  endtask

  task automatic fast(input int n);
    tick_fast = 1; cyc(n); tick_fast = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v16, e16;
    cyc(2); rst_n = 1; cyc(1);
    // R1 reset state
    chk(cnt_lo == 0 && cnt_hi == 0, "R1", {cnt_hi, cnt_lo}, 0);
    chk(stat == 0 && irq == 0, "R1", {irq, stat}, 0);

    // R2 write/read sweep on both counters
    for (int v = 0; v < 256; v += 17) begin
      wr(0, 8'(v)); wr(1, 8'(255 - v));
      chk(cnt_lo == 8'(v) && cnt_hi == 8'(255 - v), "R2", {cnt_hi, cnt_lo}, {8'(255 - v), 8'(v)});
    end

    // R5 low wrap in pair mode, irq follows (R9)
    clr(); wr(0, 8'd250); fast(10);
    chk(cnt_lo == 8'd4, "R5", cnt_lo, 4);
    chk(stat == 3'b010 && irq, "R5", {irq, stat}, 4'b1010);
    irq_en = 3'b001; cyc(1);
    chk(!irq, "R9", irq, 0);
    irq_en = 3'b111;
    clr_stat = 3'b010; cyc(1); clr_stat = 0;
    chk(stat == 0 && !irq, "R9", {irq, stat}, 0);

    // R3 source select
    wr(0, 8'd20); cfg_src_lo = 1; fast(5);
    chk(cnt_lo == 8'd20, "R3", cnt_lo, 20);
    tick_slow = 1; cyc(5); tick_slow = 0;
    chk(cnt_lo == 8'd25, "R3", cnt_lo, 25);
    cfg_src_lo = 3; fast(3);
    chk(cnt_lo == 8'd28, "R3", cnt_lo, 28);
    cfg_src_lo = 0;
    for (int p = 0; p < 3; p++) begin
      ext_clk_lo = 1; cyc(4); ext_clk_lo = 0; cyc(4);
    end
    chk(cnt_lo == 8'd31, "R3", cnt_lo, 31);
    cfg_src_lo = 2;

    // R4 halt, R5 high wrap in pair mode
    clr(); cfg_run = 0; cfg_src_hi = 2; wr(1, 8'hFD); fast(3);
    chk(cnt_lo == 8'd31, "R4", cnt_lo, 31);
    chk(cnt_hi == 8'h00 && stat == 3'b100, "R5", {stat, cnt_hi}, 12'h400);
    cfg_src_hi = 1; cfg_run = 1;

    // R6 R7 chained sweep
    cfg_chain = 1;
    for (int k = 0; k < 8; k++) begin
      v16 = 16'(k * 8191 + 13);
      e16 = v16 + 16'd300;
      clr(); wr(0, v16[7:0]); wr(1, v16[15:8]);
      tick_fast = 1; tick_slow = 1; cyc(300); tick_fast = 0; tick_slow = 0;
      chk({cnt_hi, cnt_lo} == e16, "R6", {cnt_hi, cnt_lo}, e16);
      chk(!stat[1] && stat[2] == (e16 < v16), "R7", stat, {e16 < v16, 2'b00});
    end
    clr(); wr(0, 8'hFF); wr(1, 8'hFF); fast(1);
    chk({cnt_hi, cnt_lo} == 0 && stat == 3'b100, "R7", {stat, cnt_hi, cnt_lo}, 20'h40000);
    cfg_chain = 0;

    // R4 R8 gating
    clr(); wr(0, 8'd0); cfg_run = 2; gate_in1 = 1; fast(5);
    chk(cnt_lo == 0, "R4", cnt_lo, 0);
    gate_in0 = 1; cyc(3); fast(4);
    chk(cnt_lo == 8'd4 && stat == 0, "R4", {stat, cnt_lo}, 4);
    gate_in0 = 0; cyc(3);
    chk(stat == 3'b001 && irq, "R8", {irq, stat}, 4'b1001);
    cfg_run = 3; fast(2);
    chk(cnt_lo == 8'd6, "R4", cnt_lo, 6);
    clr(); cfg_run = 1; gate_in0 = 1; cyc(3); gate_in0 = 0; cyc(4);
    chk(stat[0] == 0, "R8", stat, 0);
    gate_in1 = 0;

    // R9 set wins over clear in the same cycle
    clr(); wr(0, 8'hFF); fast(1); wr(0, 8'hFF);
    tick_fast = 1; clr_stat = 3'b010; cyc(1); tick_fast = 0; clr_stat = 0;
    chk(stat[1] == 1, "R9", stat, 3'b010);

    // R10 write beats increment
    clr(); wr(0, 8'd10);
    tick_fast = 1; wr(0, 8'd77); tick_fast = 0;
    chk(cnt_lo == 8'd77, "R10", cnt_lo, 77);
    wr(0, 8'hFF);
    tick_fast = 1; wr(0, 8'd5); tick_fast = 0;
    chk(cnt_lo == 8'd5 && stat == 0, "R10", {stat, cnt_lo}, 5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule